// File: doc/BRIEF.md
# Transmit Feed-Forward Equalizer

This block shapes a serial bit stream before it reaches the line driver. Each unit interval (UI) one binary symbol arrives, is mapped to +1 or -1, and enters a short tapped delay line. The block weights the next symbol (pre-cursor), the current symbol (main cursor) and one to three earlier symbols (post-cursors) with signed programmable coefficients, adds them, and emits a saturated signed drive level for the DAC. A correctly programmed set of coefficients has absolute values that total full scale. With such a set, a bit that stands alone or starts a new value gets a large swing, and the inner bits of a long run are backed off. This cancels the trailing echo that a lossy channel adds.

The pre-cursor tap needs the symbol that follows, so the drive level for symbol n leaves the block only after symbol n+1 has been accepted. Software, or a training engine, loads coefficients one at a time into a staging bank. The staged set becomes active only at a UI boundary, so each output uses one consistent set. A flag reports when the active set adds up to more than full scale.

Top module: `tx_ffe`

## Requirements
- R1: While rst_ni is low and after it rises, level_o is 0, level_valid_o is 0 and over_scale_o is 0. The delay line holds -1 symbols. The coefficients are tap 0 = -13, tap 1 = +90, tap 2 = -25, taps 3 and 4 = 0. Coefficients are two's complement Q1.7, so full scale is 128.
- R2: Bit 1 maps to +1 and bit 0 to -1. Tap 0 is the pre-cursor and weights x[n+1]. Tap 1 is the main cursor and weights x[n]. Tap k (k >= 2) weights x[n+1-k]. The level is the sum of weight times symbol, in units of 2^-7.
- R3: Every cycle with sym_valid_i high is followed one cycle later by exactly one cycle with level_valid_o high. That cycle carries the level for the symbol accepted in the previous valid cycle. No other cycle has level_valid_o high.
- R4: In a cycle where sym_valid_i is low, the delay line does not advance and level_o keeps its value.
- R5: With the reset coefficients, an isolated bit (0,1,0) gives +128. The first 1 of a run preceded by 0 gives +102. A 1 with 1 on both sides gives +52.
- R6: The level saturates to the signed 10-bit range [-512, +511].
- R7: A write (wgt_we_i, wgt_idx_i, wgt_data_i) goes to a staging bank. The staged set becomes active at the clock edge of the next valid symbol. The output computed at that same edge still uses the old set.
- R8: A write whose index is NUM_TAPS or larger is ignored.
- R9: over_scale_o is 1 exactly when the sum of absolute values of the active coefficients exceeds 128. Staged but uncommitted writes do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sym_valid_i | input | 1 | A new symbol is presented this cycle (one UI) |
| sym_i | input | 1 | Symbol bit, 1 = +1, 0 = -1 |
| wgt_we_i | input | 1 | Coefficient write strobe |
| wgt_idx_i | input | IDX_W | Tap index to write |
| wgt_data_i | input | WGT_W | Signed Q1.7 coefficient |
| level_o | output | OUT_W | Signed saturated drive level |
| level_valid_o | output | 1 | level_o updated this cycle |
| over_scale_o | output | 1 | Active coefficients exceed full scale |

## Verification
The hardest case to reach from the ports is the moment a staged coefficient set takes over. It is the edge where the output must still use the old set while the window shifts and the new set becomes active. The stimulus reaches it by staging several writes during idle cycles, some of them pushing the total past full scale. The flag is checked before commit, and then one symbol commits the set, and the next outputs must switch. Saturation needs every tap at -128 with constant runs of both polarities, and the de-emphasis levels need exact short patterns right after reset.

// File: rtl/tx_ffe_pkg.sv
package tx_ffe_pkg;

  localparam int MAX_TAPS = 5;
  localparam int MIN_TAPS = 3;
  localparam int REF_W    = 8;

  // Reset coefficients in Q1.7, scaled up when WGT_W > REF_W.
  function automatic int dflt_wgt(input int idx, input int wgt_w);
    int v;
    case (idx)
      0:       v = -13;
      1:       v = 90;
      2:       v = -25;
      default: v = 0;
    endcase
    return v * (1 << (wgt_w - REF_W));
  endfunction

endpackage

// File: rtl/tx_ffe_coef_bank.sv
module tx_ffe_coef_bank #(
  parameter int NUM_TAPS = 5,
  parameter int WGT_W    = 8,
  parameter int IDX_W    = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              commit_i,
  input  logic                              we_i,
  input  logic [IDX_W-1:0]                  idx_i,
  input  logic [WGT_W-1:0]                  data_i,
  output logic [NUM_TAPS-1:0][WGT_W-1:0]    wgt_o,
  output logic                              over_scale_o
);
  import tx_ffe_pkg::*;

  localparam int SUM_W = WGT_W + $clog2(NUM_TAPS) + 1;
  localparam logic [SUM_W-1:0] FULL = SUM_W'(1) << (WGT_W - 1);

  logic [NUM_TAPS-1:0][WGT_W-1:0] stage_q;
  logic [NUM_TAPS-1:0][WGT_W-1:0] act_q;
  logic [SUM_W-1:0]               mag [NUM_TAPS];
  logic [SUM_W-1:0]               mag_sum;

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    localparam logic [WGT_W-1:0] DFLT = WGT_W'(dflt_wgt(k, WGT_W));
    logic signed [SUM_W-1:0] w_ext;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[k] <= DFLT;
      end else if (we_i && (idx_i == IDX_W'(k))) begin
        stage_q[k] <= data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q[k] <= DFLT;
      end else if (commit_i) begin
        act_q[k] <= stage_q[k];
      end
    end

    assign w_ext  = SUM_W'($signed(act_q[k]));
    assign mag[k] = w_ext[SUM_W-1] ? SUM_W'(-w_ext) : SUM_W'(w_ext);
  end

  always_comb begin
    mag_sum = '0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      mag_sum = mag_sum + mag[k];
    end
  end

  assign wgt_o        = act_q;
  assign over_scale_o = (mag_sum > FULL);

endmodule

// File: rtl/tx_ffe_sym_window.sv
module tx_ffe_sym_window #(
  parameter int NUM_TAPS = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                adv_i,
  input  logic                sym_i,
  output logic [NUM_TAPS-1:0] tap_bit_o
);
  localparam int HIST = NUM_TAPS - 1;

  // hist_q[0] = x[n], hist_q[k] = x[n-k]; bit 0 encodes -1
  logic [HIST-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else if (adv_i) begin
      hist_q <= {hist_q[HIST-2:0], sym_i};
    end
  end

  // Incoming symbol acts as the lookahead x[n+1].
  assign tap_bit_o = {hist_q, sym_i};

endmodule

// File: rtl/tx_ffe_mac.sv
module tx_ffe_mac #(
  parameter int NUM_TAPS = 5,
  parameter int WGT_W    = 8,
  parameter int OUT_W    = 10
) (
  input  logic [NUM_TAPS-1:0]            tap_bit_i,
  input  logic [NUM_TAPS-1:0][WGT_W-1:0] wgt_i,
  output logic signed [OUT_W-1:0]        level_o
);
  localparam int GROW  = $clog2(NUM_TAPS) + 1;
  localparam int ACC_W = (WGT_W + GROW > OUT_W) ? (WGT_W + GROW + 1) : (OUT_W + 1);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -ACC_W'(1 << (OUT_W - 1));

  logic signed [ACC_W-1:0] term [NUM_TAPS];
  logic signed [ACC_W-1:0] acc;

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_term
    logic signed [ACC_W-1:0] w_ext;
    assign w_ext   = ACC_W'($signed(wgt_i[k]));
    assign term[k] = tap_bit_i[k] ? w_ext : -w_ext;
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      acc = acc + term[k];
    end
  end

  always_comb begin
    if (acc > SAT_HI) begin
      level_o = SAT_HI[OUT_W-1:0];
    end else if (acc < SAT_LO) begin
      level_o = SAT_LO[OUT_W-1:0];
    end else begin
      level_o = acc[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/tx_ffe.sv
module tx_ffe #(
  parameter int NUM_TAPS = 5,
  parameter int WGT_W    = 8,
  parameter int OUT_W    = 10,
  parameter int IDX_W    = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sym_valid_i,
  input  logic                    sym_i,
  input  logic                    wgt_we_i,
  input  logic [IDX_W-1:0]        wgt_idx_i,
  input  logic [WGT_W-1:0]        wgt_data_i,
  output logic signed [OUT_W-1:0] level_o,
  output logic                    level_valid_o,
  output logic                    over_scale_o
);

  logic [NUM_TAPS-1:0]            tap_bit;
  logic [NUM_TAPS-1:0][WGT_W-1:0] wgt_act;
  logic signed [OUT_W-1:0]        level_d;

  tx_ffe_coef_bank #(
    .NUM_TAPS (NUM_TAPS),
    .WGT_W    (WGT_W),
    .IDX_W    (IDX_W)
  ) u_coef (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (sym_valid_i),
    .we_i         (wgt_we_i),
    .idx_i        (wgt_idx_i),
    .data_i       (wgt_data_i),
    .wgt_o        (wgt_act),
    .over_scale_o (over_scale_o)
  );

  tx_ffe_sym_window #(
    .NUM_TAPS (NUM_TAPS)
  ) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (sym_valid_i),
    .sym_i     (sym_i),
    .tap_bit_o (tap_bit)
  );

  tx_ffe_mac #(
    .NUM_TAPS (NUM_TAPS),
    .WGT_W    (WGT_W),
    .OUT_W    (OUT_W)
  ) u_mac (
    .tap_bit_i (tap_bit),
    .wgt_i     (wgt_act),
    .level_o   (level_d)
  );

  // Output register: uses weights active before this edge's commit.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o       <= '0;
      level_valid_o <= 1'b0;
    end else begin
      level_valid_o <= sym_valid_i;
      if (sym_valid_i) begin
        level_o <= level_d;
      end
    end
  end

endmodule

// File: rtl/tx_ffe_chk.sv
module tx_ffe_chk #(
  parameter int WGT_W = 8,
  parameter int OUT_W = 10
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sym_valid_i,
  input logic signed [OUT_W-1:0] level_o,
  input logic                    level_valid_o,
  input logic                    over_scale_o
);
  localparam int FULL = 1 << (WGT_W - 1);

  // R3
  a_r3_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_i |=> level_valid_o);

  // R3
  a_r3_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_i |=> !level_valid_o);

  // R4
  a_r4_level_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_i |=> $stable(level_o));

  // R7, R9: the active set only moves on a valid symbol
  a_r7_scale_flag_frozen_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_i |=> $stable(over_scale_o));

  // R9: a normalized set cannot produce more than full scale
  a_r9_bounded_when_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_valid_o && !$past(over_scale_o)) |->
      (($signed(level_o) <= FULL) && ($signed(level_o) >= -FULL)));

endmodule

bind tx_ffe tx_ffe_chk #(
  .WGT_W (WGT_W),
  .OUT_W (OUT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sym_valid_i   (sym_valid_i),
  .level_o       (level_o),
  .level_valid_o (level_valid_o),
  .over_scale_o  (over_scale_o)
);

// File: tb/tx_ffe_tb_top.sv
module tx_ffe_tb_top;

  localparam int NT    = 5;
  localparam int WGT_W = 8;
  localparam int OUT_W = 10;
  localparam int IDX_W = 3;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    sym_valid_i = 1'b0;
  logic                    sym_i = 1'b0;
  logic                    wgt_we_i = 1'b0;
  logic [IDX_W-1:0]        wgt_idx_i = '0;
  logic [WGT_W-1:0]        wgt_data_i = '0;
  logic signed [OUT_W-1:0] level_o;
  logic                    level_valid_o;
  logic                    over_scale_o;

  always #2 clk_i = ~clk_i;

  tx_ffe #(.NUM_TAPS(NT), .WGT_W(WGT_W), .OUT_W(OUT_W), .IDX_W(IDX_W)) dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sym_valid_i   (sym_valid_i),
    .sym_i         (sym_i),
    .wgt_we_i      (wgt_we_i),
    .wgt_idx_i     (wgt_idx_i),
    .wgt_data_i    (wgt_data_i),
    .level_o       (level_o),
    .level_valid_o (level_valid_o),
    .over_scale_o  (over_scale_o)
  );

  typedef struct {
    int    val;
    string req;
  } exp_t;

  exp_t  sb_q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  int    m_act [NT];
  int    m_stg [NT];
  int    m_hist[NT-1];
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_step(input bit b);
    int s, e;
    s = b ? 1 : -1;
    e = m_act[0] * s;
    for (int k = 1; k < NT; k++) e += m_act[k] * m_hist[k-1];
    if (e > 511) e = 511;
    if (e < -512) e = -512;
    for (int k = NT-2; k > 0; k--) m_hist[k] = m_hist[k-1];
    m_hist[0] = s;
    for (int k = 0; k < NT; k++) m_act[k] = m_stg[k];
    return e;
  endfunction

  function automatic int mag_sum();
    int s = 0;
    for (int k = 0; k < NT; k++) s += (m_act[k] < 0) ? -m_act[k] : m_act[k];
    return s;
  endfunction

  // Driver: one symbol per call, back-to-back when called in sequence.
  task automatic send_sym(input bit b, input string req, input bit use_fix, input int fix);
    exp_t it;
    int   e;
    e = model_step(b);
    it.val = use_fix ? fix : e;
    it.req = req;
    @(negedge clk_i);
    sym_valid_i = 1'b1;
    sym_i       = b;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      sym_valid_i = 1'b0;
    end
  endtask

  task automatic wr(input int idx, input int val);
    @(negedge clk_i);
    sym_valid_i = 1'b0;
    wgt_we_i    = 1'b1;
    wgt_idx_i   = IDX_W'(idx);
    wgt_data_i  = WGT_W'(val);
    if (idx < NT) m_stg[idx] = int'($signed(WGT_W'(val)));
    @(negedge clk_i);
    wgt_we_i = 1'b0;
  endtask

  task automatic lfsr_stream(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send_sym(lfsr[0], req, 1'b0, 0);
      if (lfsr[3] && lfsr[7]) idle(2);
    end
  endtask

  // Monitor: pops one expectation per valid output.
  always @(negedge clk_i) begin
    if (rst_ni && level_valid_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R3 unexpected output", int'(level_o), 0);
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        check(int'(level_o) == it.val, it.req, int'(level_o), it.val);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int hold;
    m_act[0] = -13; m_act[1] = 90; m_act[2] = -25; m_act[3] = 0; m_act[4] = 0;
    for (int k = 0; k < NT; k++) m_stg[k] = m_act[k];
    for (int k = 0; k < NT-1; k++) m_hist[k] = -1;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(level_o == 0, "R1 level", int'(level_o), 0);
    check(level_valid_o == 1'b0, "R1 valid", int'(level_valid_o), 0);
    check(over_scale_o == 1'b0, "R1 flag", int'(over_scale_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(level_valid_o == 1'b0, "R1 valid after release", int'(level_valid_o), 0);

    // R1 history -1, R5 de-emphasis levels with reset weights
    send_sym(1'b0, "R1 first output", 1'b1, -52);
    send_sym(1'b0, "R2 default", 1'b0, 0);
    send_sym(1'b1, "R2 default", 1'b1, -78);
    send_sym(1'b0, "R5 isolated bit", 1'b1, 128);
    send_sym(1'b1, "R2 default", 1'b1, -128);
    send_sym(1'b1, "R5 run start", 1'b1, 102);
    send_sym(1'b1, "R5 run interior", 1'b1, 52);

    // R4: idle holds output
    idle(1);
    @(negedge clk_i);
    hold = int'(level_o);
    idle(3);
    check(int'(level_o) == hold, "R4 hold", int'(level_o), hold);
    check(level_valid_o == 1'b0, "R4 no valid", int'(level_valid_o), 0);

    lfsr_stream(40, "R2 default stream");
    idle(2);

    // R7/R9: staged writes do not touch active set until a symbol
    wr(1, 64);
    wr(3, -40);
    idle(2);
    check(over_scale_o == 1'b0, "R9 staged ignored", int'(over_scale_o), 0);
    send_sym(1'b1, "R7 old weights at commit", 1'b0, 0);
    idle(1);
    check(over_scale_o == 1'b1, "R9 flag after commit", int'(over_scale_o), mag_sum() > 128);
    lfsr_stream(12, "R7 new weights");
    idle(2);

    // R8: out-of-range index writes ignored
    wr(5, 127);
    wr(7, 127);
    send_sym(1'b0, "R8 commit", 1'b0, 0);
    idle(1);
    check(over_scale_o == 1'b1, "R8 flag unchanged", int'(over_scale_o), 1);
    lfsr_stream(10, "R8 stream");
    idle(2);

    // R9: normalized five-tap set
    wr(0, -20); wr(1, 80); wr(2, -16); wr(3, -8); wr(4, -4);
    send_sym(1'b1, "R2 commit", 1'b0, 0);
    idle(1);
    check(over_scale_o == 1'b0, "R9 normalized", int'(over_scale_o), 0);
    lfsr_stream(40, "R2 five-tap stream");
    idle(2);

    // R6: saturation both ways
    for (int k = 0; k < NT; k++) wr(k, -128);
    send_sym(1'b0, "R6 commit", 1'b0, 0);
    idle(1);
    check(over_scale_o == 1'b1, "R9 overfull", int'(over_scale_o), 1);
    for (int i = 0; i < 6; i++) send_sym(1'b0, "R6 positive clip", 1'b0, 0);
    send_sym(1'b0, "R6 positive clip", 1'b1, 511);
    for (int i = 0; i < 6; i++) send_sym(1'b1, "R6 negative clip", 1'b0, 0);
    send_sym(1'b1, "R6 negative clip", 1'b1, -512);
    idle(4);

    check(sb_q.size() == 0, "R3 all outputs seen", sb_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule